// File: doc/BRIEF.md
# Peripheral I/O Instruction Sequencer

The sequencer sits between a host instruction decoder and a 16-bit peripheral register space. For every accepted request it carries out one I/O instruction as a short series of bus master cycles: a plain word or byte read or write, a bit-set or bit-clear performed as read-modify-write, or a test that ANDs a device register with an accumulator value and reports whether the host should skip. Byte forms always read the even-aligned word and pick the addressed half by address bit 0. Byte writes are issued as byte-mode cycles.

Before any bus cycle starts, the address of the first cycle is compared against a parameter table of device windows. An address outside every window produces no bus traffic. Instead the sequencer reports a fault with a page-fail word, and it sets sticky timeout and missing-device flags for the controller named by the top address bits, provided that controller is fitted. An alternate addressing mode reuses the set, clear and test opcodes as direct reads and writes that force a fixed controller number into the address.

Top module: `pio_sequencer`

## Requirements
- R1: After reset, `done`, `fault`, `bus_req`, `skip`, every `adp_tmo` bit and every `adp_nxd` bit are 0.
- R2: A word read (op 0) issues one bus read at `addr_in`. It returns the 16-bit bus data on `rdata` with `skip` = 0. Op codes 6 and 7 behave as op 0.
- R3: A byte-form read issues the bus read at `addr_in` with bit 0 cleared. `rdata` is bits 15:8 of the word when address bit 0 is 1, and bits 7:0 otherwise, zero-extended.
- R4: A write (op 1) issues one bus write at `addr_in` and no read. In word form `bus_wdata` is `operand`. In byte form `bus_byte` = 1 and `bus_wdata` carries `operand[7:0]` in bits 7:0 with bits 15:8 zero, so the device changes only the lane selected by address bit 0.
- R5: Set (op 2) reads the word, ORs in `operand` and writes the result back. Clear (op 3) reads the word, ANDs it with the inverted `operand` and writes the result back. `rdata` returns the value read before the change.
- R6: Byte-form set and clear extract the addressed byte, modify it with `operand[7:0]`, and write the result with a byte-mode cycle at `addr_in`.
- R7: Test-zero (op 4) sets `skip` when (`operand` AND data) is 0. Test-nonzero (op 5) sets `skip` when that AND is nonzero. In byte form the data is the extracted byte. A test performs one read and no write.
- R8: A device window covers the addresses from base up to base+length-1. If the first-cycle address is in no window, `fault` = 1 with `done`, and no bus cycle takes place.
- R9: On a miss the controller number is the top 4 address bits. If that controller is fitted (`ADP_PRESENT`, default controllers 1 and 3), its `adp_tmo` and `adp_nxd` bits are set and stay set until reset. A miss on an unfitted controller leaves all of these flags unchanged.
- R10: The fault word is {hard=1, virtual=1, io=1, byte, user, address}, packed from bit 22 down to bit 18, with the 18-bit address in bits 17:0. `byte` is 1 only when the failing cycle is a byte write. `user` copies `user_mode`. The address is that of the first bus cycle.
- R11: With `alt_mode` = 1, the set-slot opcode is a direct write and the clear-slot opcode is a direct write. The test-zero-slot opcode is a direct read and the test-nonzero-slot opcode is a direct read. The set and test-zero slots force controller 3 into bits 17:14 of the address, and the clear and test-nonzero slots force controller 1. Ops 0 and 1 are unchanged.
- R12: Each bus cycle holds `bus_req`, `bus_addr` and `bus_we` steady until `bus_ack` is sampled high. `done` is a one-cycle pulse per instruction. `start` and the other request inputs are ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| op_code | input | 3 | 0 read, 1 write, 2 set, 3 clear, 4 test-zero, 5 test-nonzero |
| byte_op | input | 1 | Byte form of the operation |
| alt_mode | input | 1 | Alternate direct-addressing mode |
| user_mode | input | 1 | Host is in user mode |
| addr_in | input | 18 | Peripheral address |
| operand | input | 16 | Write data, bit mask or accumulator |
| done | output | 1 | One-cycle completion pulse |
| skip | output | 1 | Test result |
| rdata | output | 16 | Read data (byte forms zero-extended) |
| fault | output | 1 | Decode miss on the last instruction |
| fault_word | output | 23 | Page-fail word |
| adp_tmo | output | 16 | Sticky timeout flag per controller |
| adp_nxd | output | 16 | Sticky missing-device flag per controller |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_byte | output | 1 | Bus write is byte-mode |
| bus_addr | output | 18 | Bus cycle address |
| bus_wdata | output | 16 | Bus write data |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | 16 | Bus read data, valid with acknowledge |

## Verification
The sequencer's internal state shows up at the ports within the same instruction. A wrong latched opcode or mode changes the number or kind of bus cycles, and a wrong byte select or merge changes the device word or `rdata` at the next `done`. A decode error appears either as a spurious fault or as a bus cycle to an address outside every window. A wrong flag update shows in `adp_tmo`/`adp_nxd` at once and stays there, because those flags are sticky. Random operations with random acknowledge delays, checked against a bench model of the device registers, are combined with directed cases at window edges, at both byte lanes and on fitted and unfitted controllers.

// File: rtl/pio_pkg.sv
// Shared constants and types of the peripheral I/O sequencer.
// Assumes a 16-bit peripheral bus made of two byte lanes.
package pio_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_SET   = 3'd2,
        OP_CLR   = 3'd3,
        OP_TSTZ  = 3'd4,
        OP_TSTNZ = 3'd5
    } pio_op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DEC  = 3'd1,
        S_RD   = 3'd2,
        S_WR   = 3'd3,
        S_FIN  = 3'd4
    } pio_state_e;
endpackage

// File: rtl/pio_decode.sv
// Address decoder: flags whether an address falls inside any device window.
// Assumes windows given as packed base/length arrays, window 0 in the low bits.
module pio_decode #(
    parameter int ADDR_W = 18,
    parameter int N_WIN  = 4,
    parameter logic [N_WIN*ADDR_W-1:0] WIN_BASE = '0,
    parameter logic [N_WIN*ADDR_W-1:0] WIN_LEN  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [N_WIN-1:0] in_win;

    // one half-open range compare per window, one bit wider to avoid wrap
    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        localparam logic [ADDR_W:0] LO = {1'b0, WIN_BASE[g*ADDR_W +: ADDR_W]};
        localparam logic [ADDR_W:0] HI = LO + {1'b0, WIN_LEN[g*ADDR_W +: ADDR_W]};
        assign in_win[g] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    end

    assign hit = |in_win;
endmodule

// File: rtl/pio_alu.sv
// Byte extraction, bit set/clear merge and test evaluation for one read word.
// Assumes byte forms select the high lane when the address bit 0 is set.
module pio_alu
    import pio_pkg::*;
(
    input  logic [DATA_W-1:0] rd_word,
    input  logic              sel_hi,
    input  logic              byte_m,
    input  logic              clr_m,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] wr_val,
    output logic              and_zero
);
    logic [DATA_W-1:0] acc_m;

    // operand view and extracted data, both narrowed to a byte in byte form
    always_comb begin
        acc_m  = byte_m ? {{(DATA_W-BYTE_W){1'b0}}, acc[BYTE_W-1:0]} : acc;
        rd_val = rd_word;
        if (byte_m)
            rd_val = {{(DATA_W-BYTE_W){1'b0}},
                      sel_hi ? rd_word[DATA_W-1:BYTE_W] : rd_word[BYTE_W-1:0]};
    end

    // modified value for the write-back and the AND test
    always_comb begin
        wr_val   = clr_m ? (rd_val & ~acc_m) : (rd_val | acc_m);
        and_zero = ((acc_m & rd_val) == '0);
    end
endmodule

// File: rtl/pio_sequencer.sv
// Peripheral I/O instruction sequencer: turns one host I/O request into
// decode, optional bus read, optional bus write and a completion pulse.
// Assumes a bus slave that answers each held request with a one-cycle ack.
module pio_sequencer
    import pio_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CTL_W  = 4,
    parameter int N_WIN  = 4,
    parameter logic [N_WIN*ADDR_W-1:0] WIN_BASE =
        {18'h08300, 18'h0C200, 18'h0C100, 18'h04000},
    parameter logic [N_WIN*ADDR_W-1:0] WIN_LEN =
        {18'h00010, 18'h00020, 18'h00040, 18'h00040},
    parameter logic [(1<<CTL_W)-1:0] ADP_PRESENT = 16'h000A,
    parameter logic [CTL_W-1:0] ALT_CTL_A = 4'd3,
    parameter logic [CTL_W-1:0] ALT_CTL_B = 4'd1,
    localparam int N_CTL = 1 << CTL_W,
    localparam int FW_W  = ADDR_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_code,
    input  logic              byte_op,
    input  logic              alt_mode,
    input  logic              user_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] operand,
    output logic              done,
    output logic              skip,
    output logic [DATA_W-1:0] rdata,
    output logic              fault,
    output logic [FW_W-1:0]   fault_word,
    output logic [N_CTL-1:0]  adp_tmo,
    output logic [N_CTL-1:0]  adp_nxd,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_byte,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    pio_state_e        state;
    logic              r_need_rd, r_need_wr, r_test, r_tst_nz, r_clr, r_byte, r_user;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_acc, wr_q;
    pio_op_e           eff_op;
    logic [ADDR_W-1:0] eff_addr, rd_addr, first_addr;
    logic [CTL_W-1:0]  miss_ctl;
    logic              hit, and_zero;
    logic [DATA_W-1:0] rd_val, wr_val;

    // alternate-mode remap of opcode and forced controller number
    always_comb begin
        eff_addr = addr_in;
        case (op_code)
            3'd1:    eff_op = OP_WRITE;
            3'd2:    eff_op = OP_SET;
            3'd3:    eff_op = OP_CLR;
            3'd4:    eff_op = OP_TSTZ;
            3'd5:    eff_op = OP_TSTNZ;
            default: eff_op = OP_READ;
        endcase
        if (alt_mode) begin
            case (op_code)
                3'd2: begin eff_op = OP_WRITE; eff_addr[ADDR_W-1 -: CTL_W] = ALT_CTL_A; end
                3'd3: begin eff_op = OP_WRITE; eff_addr[ADDR_W-1 -: CTL_W] = ALT_CTL_B; end
                3'd4: begin eff_op = OP_READ;  eff_addr[ADDR_W-1 -: CTL_W] = ALT_CTL_A; end
                3'd5: begin eff_op = OP_READ;  eff_addr[ADDR_W-1 -: CTL_W] = ALT_CTL_B; end
                default: ;
            endcase
        end
    end

    // addresses of the read cycle and of the first cycle of the instruction
    always_comb begin
        rd_addr    = r_byte ? {r_addr[ADDR_W-1:1], 1'b0} : r_addr;
        first_addr = r_need_rd ? rd_addr : r_addr;
        miss_ctl   = first_addr[ADDR_W-1 -: CTL_W];
    end

    pio_decode #(
        .ADDR_W(ADDR_W), .N_WIN(N_WIN), .WIN_BASE(WIN_BASE), .WIN_LEN(WIN_LEN)
    ) u_decode (
        .addr(first_addr),
        .hit (hit)
    );

    pio_alu u_alu (
        .rd_word (bus_rdata),
        .sel_hi  (r_addr[0]),
        .byte_m  (r_byte),
        .clr_m   (r_clr),
        .acc     (r_acc),
        .rd_val  (rd_val),
        .wr_val  (wr_val),
        .and_zero(and_zero)
    );

    // instruction sequencing, result and sticky flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            r_need_rd  <= 1'b0;
            r_need_wr  <= 1'b0;
            r_test     <= 1'b0;
            r_tst_nz   <= 1'b0;
            r_clr      <= 1'b0;
            r_byte     <= 1'b0;
            r_user     <= 1'b0;
            r_addr     <= '0;
            r_acc      <= '0;
            wr_q       <= '0;
            skip       <= 1'b0;
            rdata      <= '0;
            fault      <= 1'b0;
            fault_word <= '0;
            adp_tmo    <= '0;
            adp_nxd    <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    r_need_rd <= (eff_op != OP_WRITE);
                    r_need_wr <= (eff_op == OP_WRITE) || (eff_op == OP_SET) || (eff_op == OP_CLR);
                    r_test    <= (eff_op == OP_TSTZ) || (eff_op == OP_TSTNZ);
                    r_tst_nz  <= (eff_op == OP_TSTNZ);
                    r_clr     <= (eff_op == OP_CLR);
                    r_byte    <= byte_op;
                    r_user    <= user_mode;
                    r_addr    <= eff_addr;
                    r_acc     <= operand;
                    wr_q      <= byte_op ? {{(DATA_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]} : operand;
                    skip      <= 1'b0;
                    rdata     <= '0;
                    fault     <= 1'b0;
                    state     <= S_DEC;
                end
                S_DEC: begin
                    if (!hit) begin
                        fault      <= 1'b1;
                        fault_word <= {3'b111, (!r_need_rd && r_byte), r_user, first_addr};
                        if (ADP_PRESENT[miss_ctl]) begin
                            adp_tmo[miss_ctl] <= 1'b1;
                            adp_nxd[miss_ctl] <= 1'b1;
                        end
                        state <= S_FIN;
                    end else begin
                        state <= r_need_rd ? S_RD : S_WR;
                    end
                end
                S_RD: if (bus_ack) begin
                    rdata <= rd_val;
                    skip  <= r_test && (r_tst_nz ? !and_zero : and_zero);
                    if (r_need_wr) wr_q <= wr_val;
                    state <= r_need_wr ? S_WR : S_FIN;
                end
                S_WR: if (bus_ack) state <= S_FIN;
                default: state <= S_IDLE;
            endcase
        end
    end

    // bus master outputs decoded from the sequencing state
    always_comb begin
        done      = (state == S_FIN);
        bus_req   = (state == S_RD) || (state == S_WR);
        bus_we    = (state == S_WR);
        bus_byte  = (state == S_WR) && r_byte;
        bus_addr  = (state == S_RD) ? rd_addr : r_addr;
        bus_wdata = (state == S_WR) ? wr_q : '0;
    end

    // R12: a pending request stays put until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R12: completion is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a read issued for a byte form is always at an even address
    p_byte_rd_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && r_byte) |-> !bus_addr[0]);

    // R4: byte-mode writes never carry data in the upper lane
    p_byte_wr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_byte) |-> (bus_wdata[DATA_W-1:BYTE_W] == '0));

    // R8: a decode miss is followed by no bus cycle
    p_miss_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_DEC) && !hit) |=> (!bus_req && fault));

    // R9: the miss flags are only ever raised for fitted controllers
    p_flags_fitted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((adp_tmo & ~ADP_PRESENT) == '0) && (adp_tmo == adp_nxd));
endmodule

// File: tb/pio_sequencer_tb_top.sv
// Bench for the I/O sequencer: a bench-side register file answers the bus
// with random ack delays; every instruction is checked against a model.
module pio_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_code = '0;
    logic        byte_op = 1'b0, alt_mode = 1'b0, user_mode = 1'b0;
    logic [17:0] addr_in = '0;
    logic [15:0] operand = '0;
    logic        done, skip, fault;
    logic [15:0] rdata;
    logic [22:0] fault_word;
    logic [15:0] adp_tmo, adp_nxd;
    logic        bus_req, bus_we, bus_byte;
    logic [17:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        bus_ack = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [15:0] dev_mem [0:511];
    logic [15:0] ref_mem [0:511];
    logic [17:0] tb_base [0:3];
    logic [17:0] tb_len  [0:3];
    logic [15:0] exp_tmo = '0;
    int          n_rd, n_wr, wait_cnt;
    logic [17:0] last_wr_addr;
    logic        last_wr_byte;

    always #5 clk = ~clk;

    pio_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .byte_op(byte_op), .alt_mode(alt_mode), .user_mode(user_mode),
        .addr_in(addr_in), .operand(operand), .done(done), .skip(skip),
        .rdata(rdata), .fault(fault), .fault_word(fault_word),
        .adp_tmo(adp_tmo), .adp_nxd(adp_nxd), .bus_req(bus_req),
        .bus_we(bus_we), .bus_byte(bus_byte), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    assign bus_rdata = dev_mem[bus_addr[9:1]];

    // acknowledge generator with a random delay of 0 to 2 cycles
    always @(negedge clk) begin
        if (!rst_n || bus_ack) begin
            bus_ack  = 1'b0;
            wait_cnt = $urandom % 3;
        end else if (bus_req) begin
            if (wait_cnt == 0) bus_ack = 1'b1;
            else wait_cnt = wait_cnt - 1;
        end
    end

    // device side: completes accepted cycles and counts them
    always @(posedge clk) begin
        if (rst_n && bus_req && bus_ack) begin
            if (bus_we) begin
                n_wr++;
                last_wr_addr = bus_addr;
                last_wr_byte = bus_byte;
                if (!bus_byte) dev_mem[bus_addr[9:1]] <= bus_wdata;
                else if (bus_addr[0]) dev_mem[bus_addr[9:1]][15:8] <= bus_wdata[7:0];
                else dev_mem[bus_addr[9:1]][7:0] <= bus_wdata[7:0];
            end else begin
                n_rd++;
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish (act=hung exp=finished)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, expv);
        end
    endtask

    function automatic bit in_windows(input logic [17:0] a);
        for (int w = 0; w < 4; w++)
            if ({1'b0, a} >= {1'b0, tb_base[w]} && {1'b0, a} < {1'b0, tb_base[w]} + {1'b0, tb_len[w]})
                return 1'b1;
        return 1'b0;
    endfunction

    function automatic string op_tag(input logic [2:0] op, input bit byt, input bit alt);
        if (alt && op inside {3'd2, 3'd3, 3'd4, 3'd5}) return "R11";
        case (op)
            3'd1: return byt ? "R4" : "R4";
            3'd2, 3'd3: return byt ? "R6" : "R5";
            3'd4, 3'd5: return "R7";
            default: return byt ? "R3" : "R2";
        endcase
    endfunction

    // run one instruction and compare it with the model of the requirements
    task automatic run_op(input logic [2:0] op, input bit byt, input bit alt,
                          input bit usr, input logic [17:0] a, input logic [15:0] d,
                          input string tag_in);
        logic [2:0]  eop = (op > 3'd5) ? 3'd0 : op;
        logic [17:0] ea = a;
        logic [17:0] first;
        bit          nrd, nwr, hit, xskip, xfault;
        logic [15:0] w, val, xrd, nv, m8;
        logic [22:0] xfw = '0;
        string       tag = (tag_in == "") ? op_tag(op, byt, alt) : tag_in;
        int          cyc = 0;
        if (alt) begin
            case (op)
                3'd2: begin eop = 3'd1; ea[17:14] = 4'd3; end
                3'd3: begin eop = 3'd1; ea[17:14] = 4'd1; end
                3'd4: begin eop = 3'd0; ea[17:14] = 4'd3; end
                3'd5: begin eop = 3'd0; ea[17:14] = 4'd1; end
                default: ;
            endcase
        end
        nrd   = (eop != 3'd1);
        nwr   = eop inside {3'd1, 3'd2, 3'd3};
        first = (nrd && byt) ? {ea[17:1], 1'b0} : ea;
        hit   = in_windows(first);
        xskip = 1'b0; xrd = '0; xfault = !hit;
        if (!hit) begin
            xfw = {3'b111, (!nrd && byt), usr, first};
            if (first[17:14] == 4'd1 || first[17:14] == 4'd3) exp_tmo[first[17:14]] = 1'b1;
        end else begin
            w   = ref_mem[ea[9:1]];
            val = byt ? {8'h00, (ea[0] ? w[15:8] : w[7:0])} : w;
            m8  = byt ? {8'h00, d[7:0]} : d;
            if (nrd) xrd = val;
            if (eop == 3'd4) xskip = ((m8 & val) == 0);
            if (eop == 3'd5) xskip = ((m8 & val) != 0);
            nv = (eop == 3'd1) ? m8 : (eop == 3'd2) ? (val | m8) : (val & ~m8);
            if (nwr) begin
                if (!byt) ref_mem[ea[9:1]] = nv;
                else if (ea[0]) ref_mem[ea[9:1]][15:8] = nv[7:0];
                else ref_mem[ea[9:1]][7:0] = nv[7:0];
            end
        end
        @(negedge clk);
        op_code = op; byte_op = byt; alt_mode = alt; user_mode = usr;
        addr_in = a; operand = d; start = 1'b1;
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        // R12: inputs and start are scrambled while the instruction runs
        while (!done && cyc < 60) begin
            start = $urandom_range(0, 1); op_code = 3'($urandom);
            addr_in = 18'($urandom); operand = 16'($urandom);
            byte_op = 1'($urandom); alt_mode = 1'($urandom);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done, "R12", "done seen", 32'(done), 1);
        check(fault == xfault, "R8", "fault", 32'(fault), 32'(xfault));
        if (xfault) check(fault_word == xfw, "R10", "fault word", 32'(fault_word), 32'(xfw));
        check(adp_tmo == exp_tmo && adp_nxd == exp_tmo, "R9", "controller flags",
              {adp_nxd, adp_tmo}, {exp_tmo, exp_tmo});
        check(rdata == xrd, tag, "rdata", 32'(rdata), 32'(xrd));
        check(skip == xskip, tag, "skip", 32'(skip), 32'(xskip));
        check(n_rd == int'(hit && nrd) && n_wr == int'(hit && nwr), "R12", "bus cycle counts",
              32'(n_rd * 16 + n_wr), 32'((hit && nrd) * 16 + (hit && nwr)));
        if (hit && nwr)
            check(last_wr_addr == ea && last_wr_byte == byt, tag, "write addr/mode",
                  {13'd0, last_wr_byte, last_wr_addr}, {13'd0, byt, ea});
        check(dev_mem[ea[9:1]] == ref_mem[ea[9:1]], tag, "device word",
              32'(dev_mem[ea[9:1]]), 32'(ref_mem[ea[9:1]]));
        @(negedge clk);
        check(!done, "R12", "done pulse width", 32'(done), 0);
    endtask

    function automatic logic [17:0] rand_addr();
        int w;
        if ($urandom % 10 < 8) begin
            w = $urandom % 4;
            return tb_base[w] + 18'($urandom % tb_len[w]);
        end
        return 18'($urandom);
    endfunction

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        tb_base[0] = 18'h04000; tb_len[0] = 18'h40;
        tb_base[1] = 18'h0C100; tb_len[1] = 18'h40;
        tb_base[2] = 18'h0C200; tb_len[2] = 18'h20;
        tb_base[3] = 18'h08300; tb_len[3] = 18'h10;
        for (int i = 0; i < 512; i++) begin
            v = 16'($urandom);
            dev_mem[i] = v; ref_mem[i] = v;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done && !fault && !bus_req && !skip, "R1", "control outputs at reset",
              {28'd0, done, fault, bus_req, skip}, 0);
        check(adp_tmo == 0 && adp_nxd == 0, "R1", "flags at reset", {adp_nxd, adp_tmo}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(3'd0, 0, 0, 0, 18'h04010, 16'h0, "R2");       // word read
        run_op(3'd7, 0, 0, 0, 18'h0C104, 16'h0, "R2");       // op 7 reads
        run_op(3'd0, 1, 0, 0, 18'h04013, 16'h0, "R3");       // odd byte
        run_op(3'd0, 1, 0, 0, 18'h04012, 16'h0, "R3");       // even byte
        run_op(3'd1, 0, 0, 0, 18'h04020, 16'hBEEF, "R4");
        run_op(3'd1, 1, 0, 0, 18'h04021, 16'hAB5A, "R4");    // upper operand ignored
        run_op(3'd2, 0, 0, 0, 18'h0C110, 16'h00F0, "R5");
        run_op(3'd3, 0, 0, 0, 18'h0C110, 16'h0F0F, "R5");
        run_op(3'd2, 1, 0, 0, 18'h0C201, 16'hFF81, "R6");
        run_op(3'd3, 1, 0, 0, 18'h0C200, 16'h0003, "R6");
        run_op(3'd1, 0, 0, 0, 18'h0C120, 16'h00F0, "R7");
        run_op(3'd4, 0, 0, 0, 18'h0C120, 16'h0F0F, "R7");    // zero AND, skip
        run_op(3'd4, 0, 0, 0, 18'h0C120, 16'h0010, "R7");    // no skip
        run_op(3'd5, 0, 0, 0, 18'h0C120, 16'h0010, "R7");    // skip
        run_op(3'd5, 1, 0, 0, 18'h0C121, 16'hFFFF, "R7");    // high byte is 0, no skip
        run_op(3'd0, 0, 0, 0, 18'h0830F, 16'h0, "R8");       // last address of window
        run_op(3'd0, 0, 0, 0, 18'h08310, 16'h0, "R8");       // one past, unfitted ctl
        run_op(3'd0, 0, 0, 0, 18'h0C0FF, 16'h0, "R9");       // below base, ctl 3
        run_op(3'd1, 1, 0, 1, 18'h04041, 16'h0012, "R10");   // byte write miss, user
        run_op(3'd2, 1, 0, 1, 18'h04041, 16'h0012, "R10");   // RMW miss: no byte flag
        run_op(3'd4, 0, 1, 0, 18'h00110, 16'hFFFF, "R11");   // read from ctl 3
        run_op(3'd5, 1, 1, 0, 18'h3C011, 16'h0, "R11");      // byte read from ctl 1
        run_op(3'd2, 0, 1, 0, 18'h00204, 16'h1357, "R11");   // write to ctl 3
        run_op(3'd3, 1, 1, 0, 18'h00031, 16'h0099, "R11");   // byte write to ctl 1
        run_op(3'd3, 0, 1, 0, 18'h00300, 16'h0099, "R11");   // forced address misses

        for (int k = 0; k < 300; k++)
            run_op(3'($urandom % 8), 1'($urandom), ($urandom % 4) == 0, 1'($urandom),
                   rand_addr(), 16'($urandom), "");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule